// File: doc/BRIEF.md
# Packed string compare result generator

This block closes a packed string comparison datapath. Upstream logic compares the elements of two string fragments and reduces the outcome to a 16-bit match vector. This block takes that vector together with the two signed explicit lengths and turns them into results: a clamped length and a valid-lane mask for each operand, a scan index into the match vector, and six condition flags.

Two mode inputs shape the result. One selects 16 byte lanes or 8 word lanes. The other selects whether the index reports the lowest or the highest hit. A wide-mode input chooses whether each length is read as a 64-bit or a 32-bit signed number. The logic is combinational. A parameter can add one register stage on all outputs, and that stage is cleared by reset.

Top module: `str_cmp_result`

## Requirements
- R1: With wide_i=1 each length is read as a 64-bit signed value. With wide_i=0 only bits 31:0 are used, sign-extended, and bits 63:32 have no effect.
- R2: The effective length is the magnitude of the signed length, clamped to the lane count. The most negative value in either width clamps to the lane count and never wraps.
- R3: word_mode_i=0 selects 16 byte lanes (lane count 16). word_mode_i=1 selects 8 word lanes (lane count 8).
- R4: Each valid mask has exactly its lowest L bits set, where L is that operand's effective length. All other bits are clear.
- R5: With scan_high_i=0 the index is the position of the lowest set bit of the active match vector.
- R6: With scan_high_i=1 the index is the position of the highest set bit of the active match vector.
- R7: When the active match vector is zero, the index equals the lane count (16 or 8).
- R8: In word mode, match bits 15:8 have no effect on the index or on the flags.
- R9: cf_o is 1 exactly when the active match vector is nonzero.
- R10: zf_o is 1 when the effective length of operand B is below the lane count. sf_o applies the same test to operand A.
- R11: of_o equals match bit 0. af_o and pf_o are always 0.
- R12: With OUT_REG=1 every output appears one clock after its inputs, and every output is 0 while rst_ni is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wide_i | input | 1 | 1: lengths are 64-bit signed; 0: lengths are 32-bit signed |
| word_mode_i | input | 1 | Lane size: 0 selects bytes, 1 selects words |
| scan_high_i | input | 1 | Index direction: 0 reports the lowest hit, 1 the highest |
| len_a_i | input | 64 | Signed length of operand A |
| len_b_i | input | 64 | Signed length of operand B |
| match_i | input | 16 | Match vector from the aggregation stage |
| len_a_eff_o | output | 5 | Clamped length of A |
| len_b_eff_o | output | 5 | Clamped length of B |
| mask_a_o | output | 16 | Valid-lane mask of A |
| mask_b_o | output | 16 | Valid-lane mask of B |
| index_o | output | 32 | Scan index, or the lane count when there is no hit |
| cf_o | output | 1 | Match vector is nonzero |
| zf_o | output | 1 | Operand B is shorter than the lane count |
| sf_o | output | 1 | Operand A is shorter than the lane count |
| of_o | output | 1 | Match bit 0 |
| af_o | output | 1 | Always 0 |
| pf_o | output | 1 | Always 0 |

## Verification
The assertions compare registered outputs with inputs that the checker delays by one stage. This assumes the mode bits and the match vector sampled at one edge are what produced the outputs seen at the next edge, so every assertion is held off until one clock edge after reset. The assertions also assume that the lane mode applied to the match vector is the same mode applied to the lengths. The bench meets both conditions. It changes inputs only on the falling edge and presents each input set as one coherent vector.

// File: rtl/strc_pkg.sv
package strc_pkg;
  localparam int unsigned LEN_W  = 64;
  localparam int unsigned MAX_EL = 16;
  localparam int unsigned HALF   = MAX_EL / 2;
  localparam int unsigned IDX_W  = 32;
  localparam int unsigned CNT_W  = $clog2(MAX_EL + 1);

  typedef struct packed {
    logic [CNT_W-1:0]  eff_a;
    logic [CNT_W-1:0]  eff_b;
    logic [MAX_EL-1:0] mask_a;
    logic [MAX_EL-1:0] mask_b;
    logic [IDX_W-1:0]  idx;
    logic              cf;
    logic              zf;
    logic              sf;
    logic              of;
    logic              af;
    logic              pf;
  } res_t;
endpackage

// File: rtl/strc_len_sat.sv
module strc_len_sat #(
  parameter int unsigned LEN_W  = 64,
  parameter int unsigned MAX_EL = 16,
  parameter int unsigned CNT_W  = $clog2(MAX_EL + 1)
) (
  input  logic              wide_i,
  input  logic [CNT_W-1:0]  lim_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [CNT_W-1:0]  eff_o,
  output logic [MAX_EL-1:0] mask_o,
  output logic              short_o
);
  logic signed [LEN_W-1:0] s;
  logic signed [LEN_W-1:0] lim_s;
  logic                    sat;
  logic [CNT_W-1:0]        mag;

  assign s     = wide_i ? $signed(len_i) : $signed({{(LEN_W-32){len_i[31]}}, len_i[31:0]});
  assign lim_s = $signed({{(LEN_W-CNT_W){1'b0}}, lim_i});
  // compare before negating so the most negative value cannot wrap
  assign sat   = (s > lim_s) || (s < -lim_s);
  assign mag   = s[LEN_W-1] ? (~s[CNT_W-1:0] + CNT_W'(1)) : s[CNT_W-1:0];
  assign eff_o = sat ? lim_i : mag;
  assign short_o = eff_o < lim_i;

  for (genvar i = 0; i < MAX_EL; i++) begin : g_mask
    assign mask_o[i] = CNT_W'(i) < eff_o;
  end
endmodule

// File: rtl/strc_idx_find.sv
module strc_idx_find #(
  parameter int unsigned MAX_EL = 16,
  parameter int unsigned CNT_W  = $clog2(MAX_EL + 1)
) (
  input  logic [MAX_EL-1:0] vec_i,
  input  logic              scan_high_i,
  input  logic [CNT_W-1:0]  lim_i,
  output logic [CNT_W-1:0]  idx_o
);
  logic [CNT_W-1:0] lo_idx;
  logic [CNT_W-1:0] hi_idx;

  always_comb begin
    lo_idx = lim_i;
    for (int i = MAX_EL - 1; i >= 0; i--) begin
      if (vec_i[i]) lo_idx = CNT_W'(i);
    end
  end

  always_comb begin
    hi_idx = lim_i;
    for (int i = 0; i < MAX_EL; i++) begin
      if (vec_i[i]) hi_idx = CNT_W'(i);
    end
  end

  assign idx_o = scan_high_i ? hi_idx : lo_idx;
endmodule

// File: rtl/str_cmp_result.sv
module str_cmp_result
  import strc_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              word_mode_i,
  input  logic              scan_high_i,
  input  logic [LEN_W-1:0]  len_a_i,
  input  logic [LEN_W-1:0]  len_b_i,
  input  logic [MAX_EL-1:0] match_i,
  output logic [CNT_W-1:0]  len_a_eff_o,
  output logic [CNT_W-1:0]  len_b_eff_o,
  output logic [MAX_EL-1:0] mask_a_o,
  output logic [MAX_EL-1:0] mask_b_o,
  output logic [IDX_W-1:0]  index_o,
  output logic              cf_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              of_o,
  output logic              af_o,
  output logic              pf_o
);
  logic [CNT_W-1:0]  lim;
  logic [MAX_EL-1:0] vec;
  logic [CNT_W-1:0]  idx;
  logic              short_a, short_b;
  res_t              res_d, res_q;

  assign lim = word_mode_i ? CNT_W'(HALF) : CNT_W'(MAX_EL);
  assign vec = word_mode_i ? {{(MAX_EL-HALF){1'b0}}, match_i[HALF-1:0]} : match_i;

  strc_len_sat #(.LEN_W(LEN_W), .MAX_EL(MAX_EL), .CNT_W(CNT_W)) u_sat_a (
    .wide_i (wide_i),
    .lim_i  (lim),
    .len_i  (len_a_i),
    .eff_o  (res_d.eff_a),
    .mask_o (res_d.mask_a),
    .short_o(short_a)
  );

  strc_len_sat #(.LEN_W(LEN_W), .MAX_EL(MAX_EL), .CNT_W(CNT_W)) u_sat_b (
    .wide_i (wide_i),
    .lim_i  (lim),
    .len_i  (len_b_i),
    .eff_o  (res_d.eff_b),
    .mask_o (res_d.mask_b),
    .short_o(short_b)
  );

  strc_idx_find #(.MAX_EL(MAX_EL), .CNT_W(CNT_W)) u_idx (
    .vec_i      (vec),
    .scan_high_i(scan_high_i),
    .lim_i      (lim),
    .idx_o      (idx)
  );

  assign res_d.idx = IDX_W'(idx);
  assign res_d.cf  = |vec;
  assign res_d.zf  = short_b;
  assign res_d.sf  = short_a;
  assign res_d.of  = vec[0];
  assign res_d.af  = 1'b0;
  assign res_d.pf  = 1'b0;

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) res_q <= '0;
      else         res_q <= res_d;
    end
  end else begin : g_comb
    assign res_q = res_d;
  end

  assign len_a_eff_o = res_q.eff_a;
  assign len_b_eff_o = res_q.eff_b;
  assign mask_a_o    = res_q.mask_a;
  assign mask_b_o    = res_q.mask_b;
  assign index_o     = res_q.idx;
  assign cf_o        = res_q.cf;
  assign zf_o        = res_q.zf;
  assign sf_o        = res_q.sf;
  assign of_o        = res_q.of;
  assign af_o        = res_q.af;
  assign pf_o        = res_q.pf;
endmodule

// File: rtl/str_cmp_result_chk.sv
module str_cmp_result_chk
  import strc_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              word_mode_i,
  input logic              scan_high_i,
  input logic [MAX_EL-1:0] match_i,
  input logic [CNT_W-1:0]  len_a_eff_o,
  input logic [CNT_W-1:0]  len_b_eff_o,
  input logic [MAX_EL-1:0] mask_a_o,
  input logic [MAX_EL-1:0] mask_b_o,
  input logic [IDX_W-1:0]  index_o,
  input logic              cf_o,
  input logic              zf_o,
  input logic              sf_o,
  input logic              of_o,
  input logic              af_o,
  input logic              pf_o
);
  logic              word_al, scan_al;
  logic [MAX_EL-1:0] match_al, vec_al;
  logic [IDX_W-1:0]  lim_al;
  logic              armed;

  if (OUT_REG) begin : g_al
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_al  <= 1'b0;
        scan_al  <= 1'b0;
        match_al <= '0;
      end else begin
        word_al  <= word_mode_i;
        scan_al  <= scan_high_i;
        match_al <= match_i;
      end
    end
  end else begin : g_al_c
    assign word_al  = word_mode_i;
    assign scan_al  = scan_high_i;
    assign match_al = match_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assign lim_al = word_al ? IDX_W'(HALF) : IDX_W'(MAX_EL);
  assign vec_al = word_al ? {{(MAX_EL-HALF){1'b0}}, match_al[HALF-1:0]} : match_al;

  p_sat_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (IDX_W'(len_a_eff_o) <= lim_al) && (IDX_W'(len_b_eff_o) <= lim_al));
  p_mask_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    ($countones(mask_a_o) == int'(len_a_eff_o)) && ($countones(mask_b_o) == int'(len_b_eff_o)));
  p_mask_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    ((mask_a_o & (mask_a_o + 16'd1)) == '0) && ((mask_b_o & (mask_b_o + 16'd1)) == '0));
  p_hit_idx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (vec_al != '0) |-> (index_o < lim_al) && vec_al[index_o[3:0]]);
  p_low_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (vec_al != '0 && !scan_al) |-> ((vec_al & ((16'd1 << index_o[3:0]) - 16'd1)) == '0));
  p_high_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (vec_al != '0 && scan_al) |-> ((vec_al >> index_o[3:0]) == 16'd1));
  p_nomatch_idx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (vec_al == '0) |-> (index_o == lim_al));
  p_word_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    word_al |-> (index_o <= IDX_W'(HALF)));
  p_carry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    cf_o == (index_o != lim_al));
  p_len_flags_r10: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (zf_o == (IDX_W'(len_b_eff_o) < lim_al)) && (sf_o == (IDX_W'(len_a_eff_o) < lim_al)));
  p_fixed_flags_r11: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    !af_o && !pf_o && (of_o == match_al[0]));
endmodule

bind str_cmp_result str_cmp_result_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .word_mode_i(word_mode_i),
  .scan_high_i(scan_high_i),
  .match_i    (match_i),
  .len_a_eff_o(len_a_eff_o),
  .len_b_eff_o(len_b_eff_o),
  .mask_a_o   (mask_a_o),
  .mask_b_o   (mask_b_o),
  .index_o    (index_o),
  .cf_o       (cf_o),
  .zf_o       (zf_o),
  .sf_o       (sf_o),
  .of_o       (of_o),
  .af_o       (af_o),
  .pf_o       (pf_o)
);

// File: tb/tb_str_cmp_result.sv
`timescale 1ns/1ps
module tb_str_cmp_result;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wide_i = 1'b0, word_mode_i = 1'b0, scan_high_i = 1'b0;
  logic [63:0] len_a_i = '0, len_b_i = '0;
  logic [15:0] match_i = '0;
  logic [4:0]  len_a_eff_o, len_b_eff_o;
  logic [15:0] mask_a_o, mask_b_o;
  logic [31:0] index_o;
  logic        cf_o, zf_o, sf_o, of_o, af_o, pf_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  str_cmp_result #(.OUT_REG(1'b1)) dut (.*);

  function automatic int ref_eff(logic [63:0] l, logic w, logic wd);
    longint s = w ? longint'(l) : longint'($signed(l[31:0]));
    longint lim = wd ? 8 : 16;
    if (s > lim || s < -lim) return int'(lim);
    return int'(s < 0 ? -s : s);
  endfunction

  function automatic int ref_idx(logic [15:0] m, logic wd, logic sh);
    int lim = wd ? 8 : 16;
    int r = lim;
    for (int i = 0; i < lim; i++) begin
      if (m[i]) begin
        if (sh) r = i;
        else if (r == lim) r = i;
      end
    end
    return r;
  endfunction

  task automatic chk(string req, string what, string cs, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s (case %s) act=%0h exp=%0h", req, what, cs, act, exp);
    end
  endtask

  task automatic apply(logic w, logic wd, logic sh, logic [63:0] la, logic [63:0] lb,
                       logic [15:0] m, string cs);
    int lim, ea, eb, ix;
    logic [15:0] act_m;
    wide_i = w; word_mode_i = wd; scan_high_i = sh;
    len_a_i = la; len_b_i = lb; match_i = m;
    @(posedge clk_i);
    @(negedge clk_i);
    lim = wd ? 8 : 16;
    act_m = wd ? {8'h00, m[7:0]} : m;
    ea = ref_eff(la, w, wd);
    eb = ref_eff(lb, w, wd);
    ix = ref_idx(m, wd, sh);
    chk("R2", "eff_a", cs, longint'(len_a_eff_o), longint'(ea));
    chk("R2", "eff_b", cs, longint'(len_b_eff_o), longint'(eb));
    chk("R4", "mask_a", cs, longint'(mask_a_o), longint'((17'd1 << ea) - 17'd1) & 64'hFFFF);
    chk("R4", "mask_b", cs, longint'(mask_b_o), longint'((17'd1 << eb) - 17'd1) & 64'hFFFF);
    chk(act_m == 0 ? "R7" : (sh ? "R6" : "R5"), "index", cs, longint'(index_o), longint'(ix));
    chk("R9", "cf", cs, longint'(cf_o), longint'(act_m != 0));
    chk("R10", "zf", cs, longint'(zf_o), longint'(eb < lim));
    chk("R10", "sf", cs, longint'(sf_o), longint'(ea < lim));
    chk("R11", "of", cs, longint'(of_o), longint'(m[0]));
    chk("R11", "af_pf", cs, longint'({af_o, pf_o}), 0);
  endtask

  function automatic logic [63:0] rand_len();
    int v;
    case ($urandom % 6)
      0: begin v = int'($urandom % 41) - 20; return {{32{v[31]}}, v}; end
      1: return {$urandom, $urandom};
      2: return {$urandom, 32'h8000_0000};
      3: return ($urandom % 2) ? 64'h8000_0000_0000_0000 : 64'h7FFF_FFFF_FFFF_FFFF;
      4: begin v = int'($urandom % 41) - 20; return {$urandom, v}; end
      default: return {32'hFFFF_FFFF, $urandom};
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    len_a_i = 64'd5; match_i = 16'hFFFF;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    // R12: outputs held at zero in reset
    chk("R12", "reset_out", "rst", longint'({len_a_eff_o, mask_a_o, index_o[15:0], cf_o, of_o}), 0);
    rst_ni = 1'b1;
    // R12: one-cycle latency, check old value before edge then new after
    wide_i = 0; word_mode_i = 0; len_a_i = 64'd3; len_b_i = 64'd20; match_i = 16'h0004;
    #1 chk("R12", "pre_edge", "lat", longint'(index_o), 0);
    apply(0, 0, 0, 64'd3, 64'd20, 16'h0004, "R12");

    apply(0, 0, 0, 64'hFFFF_FFFF_0000_0005, 64'h1234_5678_0000_000C, 16'h0010, "R1");
    apply(1, 0, 0, 64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_000C, 16'h0010, "R1");
    apply(0, 0, 1, 64'h0000_0001_FFFF_FFF9, 64'd0, 16'h8001, "R1");
    apply(1, 0, 1, 64'h0000_0001_FFFF_FFF9, 64'd0, 16'h8001, "R1");
    apply(0, 0, 0, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_8000_0000, 16'h0000, "R2");
    apply(1, 0, 0, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 16'h0000, "R2");
    apply(1, 0, 0, 64'd16, -64'sd16, 16'h0100, "R2");
    apply(1, 0, 1, 64'd17, -64'sd17, 16'h0100, "R2");
    apply(1, 0, 0, -64'sd3, 64'd15, 16'h0600, "R2");
    apply(1, 1, 0, 64'd8, -64'sd8, 16'h0000, "R3");
    apply(1, 1, 0, 64'd9, -64'sd9, 16'h0080, "R3");
    apply(0, 1, 1, 64'd7, -64'sd7, 16'h0042, "R3");
    apply(1, 1, 0, 64'd4, 64'd2, 16'hFF00, "R8");
    apply(1, 1, 1, 64'd4, 64'd2, 16'hF001, "R8");
    apply(1, 0, 0, 64'd4, 64'd2, 16'h8000, "R5");
    apply(1, 0, 1, 64'd4, 64'd2, 16'h0811, "R6");
    apply(1, 0, 1, 64'd0, 64'd0, 16'h0000, "R7");
    apply(1, 0, 0, 64'd1, 64'd1, 16'h0001, "R11");

    for (int k = 0; k < 600; k++) begin
      logic [15:0] m = ($urandom % 5 == 0) ? 16'h0000 : 16'($urandom);
      apply(1'($urandom), 1'($urandom), 1'($urandom), rand_len(), rand_len(), m, "rnd");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule